// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the system-control slice of a 32-bit RISC core. It holds the status word, the cause word and the exception return address. When the pipeline reports a fault, the block records why and where it happened. It pushes the three-level interrupt/kernel mode stack kept in the low six status bits. One cycle later it hands the fetch unit a redirect strobe, the handler address and the address after it.

A return-from-exception strobe pops the mode stack. A small coprocessor register port lets software write the status word and read all three words. A read result comes back one cycle after the request, which matches the core's delayed-load path. The block also drives a store-inhibit level, taken from the cache-isolate bit of the status word, to the load/store unit.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `redirect` is low, `redirect_pc` is 0xBFC00000 and `redirect_next_pc` is 0xBFC00004. Status, cause and return address all read as zero.
- R2: On exception entry, the cause word becomes the 5-bit code in bits [6:2], with bit 31 set exactly when the delay-slot flag is high. All other cause bits are zero.
- R3: On exception entry, the return address becomes `exc_pc`, or `exc_pc` minus 4 when the delay-slot flag is high.
- R4: On exception entry, status bits [5:0] become the old bits [3:0] followed by two zero bits. Status bits [31:6] are unchanged.
- R5: The cycle after an exception request, `redirect` is high for one cycle. `redirect_pc` is then 0xBFC00180 if status bit 22 was set, otherwise 0x80000080. `redirect_next_pc` is always `redirect_pc` + 4, and `redirect_pc` holds its value until the next exception.
- R6: A return strobe whose `rfe_funct` equals 0x10 replaces status bits [5:0] with the old bits [5:2], zero-extended. A strobe with any other `rfe_funct` has no effect.
- R7: When an exception request arrives in the same cycle as a return strobe or a status write, only the exception is applied.
- R8: A write to coprocessor register 12 replaces the whole status word. Writes to any other register number have no effect.
- R9: A read request is answered one cycle later with `cp_rd_valid` high. The data is the value held before that clock edge: register 12 gives status, 13 gives cause, 14 gives the return address, and any other number gives zero.
- R10: `store_inhibit` equals status bit 16.
- R11: When a valid return strobe and a status write arrive in the same cycle, only the return is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Exception code (4 load addr, 5 store addr, 8 syscall, 9 break, 10 illegal, 11 coproc unusable, 12 overflow) |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| rfe_req | input | 1 | Return-from-exception strobe |
| rfe_funct | input | 6 | Low six bits of the return instruction |
| cp_wr_en | input | 1 | Coprocessor register write strobe |
| cp_rd_en | input | 1 | Coprocessor register read strobe |
| cp_addr | input | 5 | Coprocessor register number |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Read data, one cycle after the request |
| cp_rd_valid | output | 1 | Read data valid |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Fetch address (boot address after reset, handler after an exception) |
| redirect_next_pc | output | 32 | Fetch address plus 4 |
| store_inhibit | output | 1 | Suppress stores (cache isolated) |

## Verification
The assertions assume the pipeline gives each request a whole cycle and holds `exc_code`, `exc_pc` and the delay flag stable for that cycle. They also assume the inputs are at known values from reset onward. The stimulus changes inputs only on the falling edge and parks every strobe low between operations. The only simultaneous requests it issues are the exception/return, exception/write and return/write pairs, which exercise the priority rules. Read results are matched in order against a queue of values computed from a bench-side model of the three registers.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int XLEN      = 32;
  localparam int MODE_W    = 6;
  localparam int CODE_W    = 5;
  localparam int CODE_LSB  = 2;
  localparam int BD_BIT    = XLEN - 1;

  localparam logic [CODE_W-1:0] EC_LOAD_ADDR  = 5'd4;
  localparam logic [CODE_W-1:0] EC_STORE_ADDR = 5'd5;
  localparam logic [CODE_W-1:0] EC_SYSCALL    = 5'd8;
  localparam logic [CODE_W-1:0] EC_BREAK      = 5'd9;
  localparam logic [CODE_W-1:0] EC_ILLEGAL    = 5'd10;
  localparam logic [CODE_W-1:0] EC_COPROC     = 5'd11;
  localparam logic [CODE_W-1:0] EC_OVERFLOW   = 5'd12;

  function automatic logic [MODE_W-1:0] mode_push(input logic [MODE_W-1:0] m);
    return {m[MODE_W-3:0], 2'b00};
  endfunction

  function automatic logic [MODE_W-1:0] mode_pop(input logic [MODE_W-1:0] m);
    return {2'b00, m[MODE_W-1:2]};
  endfunction

  function automatic logic [XLEN-1:0] cause_pack(input logic [CODE_W-1:0] code,
                                                 input logic in_delay);
    logic [XLEN-1:0] c;
    c = '0;
    c[CODE_LSB +: CODE_W] = code;
    c[BD_BIT] = in_delay;
    return c;
  endfunction

  function automatic logic [XLEN-1:0] epc_adjust(input logic [XLEN-1:0] pc,
                                                 input logic in_delay);
    return in_delay ? pc - XLEN'(4) : pc;
  endfunction

  function automatic logic [XLEN-1:0] vector_pick(input logic boot_vec,
                                                  input logic [XLEN-1:0] v_boot,
                                                  input logic [XLEN-1:0] v_norm);
    return boot_vec ? v_boot : v_norm;
  endfunction
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_ctrl_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_take,
  input  logic         rfe_take,
  input  logic         wr_take,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sr
);
  logic [MODE_W-1:0] mode_now;
  assign mode_now = sr[MODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (exc_take) begin
      sr[MODE_W-1:0] <= mode_push(mode_now);
    end else if (rfe_take) begin
      sr[MODE_W-1:0] <= mode_pop(mode_now);
    end else if (wr_take) begin
      sr <= wdata;
    end
  end

  a_r4_push_mode: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (sr[5:0] == {$past(sr[3:0]), 2'b00}) && (sr[W-1:6] == $past(sr[W-1:6])));
  a_r6_pop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_take && !exc_take) |=> (sr[5:0] == {2'b00, $past(sr[5:2])}) && (sr[W-1:6] == $past(sr[W-1:6])));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_take && !rfe_take && !wr_take) |=> $stable(sr));
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_ctrl_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] code,
  input  logic [W-1:0]      pc,
  input  logic              in_delay,
  output logic [W-1:0]      cause,
  output logic [W-1:0]      epc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      epc   <= '0;
    end else if (exc_take) begin
      cause <= cause_pack(code, in_delay);
      epc   <= epc_adjust(pc, in_delay);
    end
  end

  a_r2_cause_shape: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (cause[1:0] == 2'b00) && (cause[W-2:7] == '0) &&
                 (cause[6:2] == $past(code)) && (cause[W-1] == $past(in_delay)));
  a_r3_epc_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !in_delay) |=> (epc == $past(pc)));
  a_r3_epc_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && in_delay) |=> (epc + 32'd4 == $past(pc)));
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(cause) && $stable(epc));
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_ctrl_pkg::*;
#(
  parameter int          W       = XLEN,
  parameter logic [W-1:0] BOOT_PC = 32'hBFC0_0000,
  parameter logic [W-1:0] V_BOOT  = 32'hBFC0_0180,
  parameter logic [W-1:0] V_NORM  = 32'h8000_0080
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_take,
  input  logic         boot_vec,
  output logic         redirect,
  output logic [W-1:0] target,
  output logic [W-1:0] target_next
);
  localparam logic [W-1:0] STEP = W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      target      <= BOOT_PC;
      target_next <= BOOT_PC + STEP;
    end else begin
      redirect <= exc_take;
      if (exc_take) begin
        target      <= vector_pick(boot_vec, V_BOOT, V_NORM);
        target_next <= vector_pick(boot_vec, V_BOOT, V_NORM) + STEP;
      end
    end
  end

  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> redirect);
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> !redirect && $stable(target));
  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (target == ($past(boot_vec) ? V_BOOT : V_NORM)));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (target_next - target == STEP));
endmodule

// File: rtl/exc_cp_read.sv
module exc_cp_read
  import exc_ctrl_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int AW     = 5,
  parameter int SEL_SR = 12,
  parameter int SEL_CA = 13,
  parameter int SEL_EP = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  sr,
  input  logic [W-1:0]  cause,
  input  logic [W-1:0]  epc,
  output logic [W-1:0]  rdata,
  output logic          rd_valid
);
  localparam int NSRC = 3;
  localparam int SEL_LIST [NSRC] = '{SEL_SR, SEL_CA, SEL_EP};

  logic [W-1:0]    src [NSRC];
  logic [NSRC-1:0] hit;
  logic [W-1:0]    muxed;

  assign src[0] = sr;
  assign src[1] = cause;
  assign src[2] = epc;

  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    assign hit[g] = (addr == AW'(SEL_LIST[g]));
  end

  always_comb begin
    muxed = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (hit[k]) muxed = src[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= muxed;
    end
  end

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit == '0) |=> (rdata == '0));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter logic [31:0] BOOT_PC  = 32'hBFC0_0000,
  parameter logic [31:0] VEC_BOOT = 32'hBFC0_0180,
  parameter logic [31:0] VEC_NORM = 32'h8000_0080,
  parameter int          REG_AW   = 5,
  parameter int          REG_SR   = 12,
  parameter int          REG_CA   = 13,
  parameter int          REG_EP   = 14,
  parameter int          BEV_BIT  = 22,
  parameter int          ISO_BIT  = 16,
  parameter logic [5:0]  RFE_CODE = 6'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [4:0]        exc_code,
  input  logic [31:0]       exc_pc,
  input  logic              exc_in_delay,
  input  logic              rfe_req,
  input  logic [5:0]        rfe_funct,
  input  logic              cp_wr_en,
  input  logic              cp_rd_en,
  input  logic [REG_AW-1:0] cp_addr,
  input  logic [31:0]       cp_wdata,
  output logic [31:0]       cp_rdata,
  output logic              cp_rd_valid,
  output logic              redirect,
  output logic [31:0]       redirect_pc,
  output logic [31:0]       redirect_next_pc,
  output logic              store_inhibit
);
  logic        rfe_ok;
  logic        ev_exc;
  logic        ev_rfe;
  logic        ev_wr_sr;
  logic [31:0] sr_q, cause_q, epc_q;

  assign rfe_ok   = rfe_req && (rfe_funct == RFE_CODE);
  assign ev_exc   = exc_req;
  assign ev_rfe   = rfe_ok && !exc_req;
  assign ev_wr_sr = cp_wr_en && (cp_addr == REG_AW'(REG_SR)) && !exc_req && !rfe_ok;

  exc_status_reg #(.W(32)) u_status (
    .clk(clk), .rst_n(rst_n),
    .exc_take(ev_exc), .rfe_take(ev_rfe), .wr_take(ev_wr_sr),
    .wdata(cp_wdata), .sr(sr_q)
  );

  exc_capture #(.W(32)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .exc_take(ev_exc), .code(exc_code), .pc(exc_pc), .in_delay(exc_in_delay),
    .cause(cause_q), .epc(epc_q)
  );

  exc_redirect #(.W(32), .BOOT_PC(BOOT_PC), .V_BOOT(VEC_BOOT), .V_NORM(VEC_NORM)) u_redirect (
    .clk(clk), .rst_n(rst_n),
    .exc_take(ev_exc), .boot_vec(sr_q[BEV_BIT]),
    .redirect(redirect), .target(redirect_pc), .target_next(redirect_next_pc)
  );

  exc_cp_read #(.W(32), .AW(REG_AW), .SEL_SR(REG_SR), .SEL_CA(REG_CA), .SEL_EP(REG_EP)) u_read (
    .clk(clk), .rst_n(rst_n),
    .rd_en(cp_rd_en), .addr(cp_addr),
    .sr(sr_q), .cause(cause_q), .epc(epc_q),
    .rdata(cp_rdata), .rd_valid(cp_rd_valid)
  );

  assign store_inhibit = sr_q[ISO_BIT];

  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_exc, ev_rfe, ev_wr_sr}) <= 1);
  a_r6_bad_funct: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_req && rfe_funct != RFE_CODE && !exc_req && !cp_wr_en) |=> $stable(sr_q));
  a_r11_rfe_over_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_ok && !exc_req) |=> (sr_q[31:6] == $past(sr_q[31:6])));
endmodule

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_in_delay = 1'b0;
  logic        rfe_req = 1'b0;
  logic [5:0]  rfe_funct = '0;
  logic        cp_wr_en = 1'b0;
  logic        cp_rd_en = 1'b0;
  logic [4:0]  cp_addr = '0;
  logic [31:0] cp_wdata = '0;
  logic [31:0] cp_rdata;
  logic        cp_rd_valid;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic [31:0] redirect_next_pc;
  logic        store_inhibit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_sr = '0, m_cause = '0, m_epc = '0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  exc_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc), .exc_in_delay(exc_in_delay),
    .rfe_req(rfe_req), .rfe_funct(rfe_funct),
    .cp_wr_en(cp_wr_en), .cp_rd_en(cp_rd_en), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
    .cp_rdata(cp_rdata), .cp_rd_valid(cp_rd_valid),
    .redirect(redirect), .redirect_pc(redirect_pc), .redirect_next_pc(redirect_next_pc),
    .store_inhibit(store_inhibit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && cp_rd_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected read data", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), cp_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'd12: return m_sr;
      5'd13: return m_cause;
      5'd14: return m_epc;
      default: return 32'd0;
    endcase
  endfunction

  // model updates straight from the requirement text
  function automatic void model_exc(input logic [4:0] code, input logic [31:0] pc, input logic dly);
    m_cause = (32'(code) << 2) | (dly ? 32'h8000_0000 : 32'd0);
    m_epc   = dly ? pc - 32'd4 : pc;
    m_sr    = (m_sr & ~32'h3F) | ((m_sr << 2) & 32'h3F);
  endfunction

  task automatic rd(input logic [4:0] a, input string tag);
    cp_rd_en = 1'b1; cp_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    cp_rd_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cp_wr_en = 1'b1; cp_addr = a; cp_wdata = d;
    @(negedge clk);
    cp_wr_en = 1'b0;
    if (a == 5'd12) m_sr = d;
  endtask

  task automatic rfe(input logic [5:0] f);
    rfe_req = 1'b1; rfe_funct = f;
    @(negedge clk);
    rfe_req = 1'b0;
    if (f == 6'h10) m_sr = (m_sr & ~32'h3F) | ((m_sr & 32'h3F) >> 2);
  endtask

  task automatic raise(input logic [4:0] code, input logic [31:0] pc, input logic dly,
                       input logic also_rfe, input logic also_wr, input logic [31:0] wv);
    logic [31:0] vec;
    vec = m_sr[22] ? 32'hBFC0_0180 : 32'h8000_0080;
    exc_req = 1'b1; exc_code = code; exc_pc = pc; exc_in_delay = dly;
    rfe_req = also_rfe; rfe_funct = 6'h10;
    cp_wr_en = also_wr; cp_addr = 5'd12; cp_wdata = wv;
    @(negedge clk);
    exc_req = 1'b0; rfe_req = 1'b0; cp_wr_en = 1'b0;
    model_exc(code, pc, dly);
    chk("R5 redirect strobe", 32'(redirect), 32'd1);
    chk("R5 handler address", redirect_pc, vec);
    chk("R5 handler next", redirect_next_pc, vec + 32'd4);
    @(negedge clk);
    chk("R5 strobe single cycle", 32'(redirect), 32'd0);
    chk("R5 handler held", redirect_pc, vec);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 boot pc", redirect_pc, 32'hBFC0_0000);
    chk("R1 boot next", redirect_next_pc, 32'hBFC0_0004);
    chk("R1 no redirect", 32'(redirect), 32'd0);
    rd(5'd12, "R1 status reset");
    rd(5'd13, "R1 cause reset");
    rd(5'd14, "R1 epc reset");
    // R8 status write, R10 inhibit low
    wr(5'd12, 32'h0000_0015);
    rd(5'd12, "R8 status write");
    chk("R10 inhibit clear", 32'(store_inhibit), 32'd0);
    // R2 R3 R4 R5 plain exception
    raise(5'd8, 32'h8000_1000, 1'b0, 1'b0, 1'b0, '0);
    rd(5'd13, "R2 cause plain");
    rd(5'd14, "R3 epc plain");
    rd(5'd12, "R4 mode push");
    // R6 valid and invalid return
    rfe(6'h10);
    rd(5'd12, "R6 mode pop");
    rfe(6'h11);
    rd(5'd12, "R6 bad funct ignored");
    // R10 inhibit set, R5 boot vector, delay slot
    wr(5'd12, 32'h0041_0003);
    chk("R10 inhibit set", 32'(store_inhibit), 32'd1);
    raise(5'd12, 32'h8000_2004, 1'b1, 1'b0, 1'b0, '0);
    rd(5'd13, "R2 cause delay slot");
    rd(5'd14, "R3 epc delay slot");
    rd(5'd12, "R4 upper bits kept");
    // R8 writes to other registers ignored
    wr(5'd13, 32'hFFFF_FFFF);
    wr(5'd14, 32'h1234_5678);
    rd(5'd13, "R8 cause write ignored");
    rd(5'd14, "R8 epc write ignored");
    // R7 exception beats return, then beats status write
    raise(5'd10, 32'h0000_1000, 1'b0, 1'b1, 1'b0, '0);
    rd(5'd12, "R7 exception over return");
    raise(5'd4, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 32'h0000_003F);
    rd(5'd12, "R7 exception over write");
    rd(5'd13, "R7 cause after write clash");
    // R11 return beats status write
    wr(5'd12, 32'h0000_0030);
    rfe_req = 1'b1; rfe_funct = 6'h10;
    cp_wr_en = 1'b1; cp_addr = 5'd12; cp_wdata = 32'h0000_003F;
    @(negedge clk);
    rfe_req = 1'b0; cp_wr_en = 1'b0;
    m_sr = 32'h0000_000C;
    rd(5'd12, "R11 return over write");
    chk("R10 inhibit follows", 32'(store_inhibit), 32'd0);
    // R9 unmapped register reads zero
    rd(5'd3, "R9 unmapped read");
    repeat (3) @(negedge clk);
    chk("R9 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule